// File: doc/BRIEF.md
# UART Interrupt Status Aggregator

This block gathers every interrupt cause of a UART into a single interrupt request line. Each cause owns one bit of a raw status word. Receive-error causes and modem-line changes are latched, and software clears them by writing ones. The receive and transmit FIFO threshold bits, the transmit-complete bit and the receive time-out bit release by themselves when their source condition goes away. Software can also clear any of these four bits early.

A mask word selects which raw bits may drive the interrupt line, and a masked view shows the raw bits that are enabled. The raw word can be read whatever the mask holds. Two completion levels from an external DMA engine are ORed straight onto the interrupt line. They bypass the mask and are never stored here, because they are cleared where they come from. A small word-wide register port with two address bits gives access to the raw, mask, masked and clear locations.

Status bit positions, used in every register: 0 receive threshold, 1 transmit threshold, 2 receive time-out, 3 framing, 4 parity, 5 break, 6 overrun, 7 clear-to-send change, 8 transmit complete.

Top module: `uart_irq_agg`

## Requirements
- R1: After reset the raw status and the mask read as zero and `irq_o` is low.
- R2: A one-cycle pulse on the overrun, break, parity or framing input sets raw bits 6, 5, 4 or 3 at the next clock edge. The bit then stays set until software clears it.
- R3: A write to address 3 clears exactly the raw bits whose write-data bit is 1. The same bits drop from the masked view, and the other bits are left unchanged.
- R4: When a set event and a clear write hit the same bit in the same cycle, the bit ends up set.
- R5: Raw bit 0 sets when `rx_at_trig_i` rises and clears in the cycle after it goes low. If software clears the bit while the input is still high, the bit stays clear until the input rises again.
- R6: Raw bit 1 follows `tx_at_trig_i` in the same way as R5.
- R7: Raw bit 8 sets when `tx_line_idle_i` and `tx_fifo_empty_i` first become high together. It releases once either of them is low.
- R8: Raw bit 2 sets on a pulse of `evt_rx_tmo_i`. It releases when `rx_fifo_empty_i` is high or when software clears it.
- R9: A change of `cts_i` in either direction sets raw bit 7 after SYNC_STAGES+1 clock edges, and not earlier than two edges. The bit then stays set until it is cleared.
- R10: Address 2 reads the raw status ANDed with the mask. Address 0 reads the raw status whatever the mask value is.
- R11: `irq_o` is high exactly when the masked status is nonzero or a DMA-done input is high. With a zero mask and both DMA inputs low, it stays low.
- R12: A high level on either `rx_dma_done_i` or `tx_dma_done_i` drives `irq_o` high whatever the mask is, and it changes no raw status bit.
- R13: Address 1 is the read/write mask (bits 8:0). Writes to addresses 0 and 2 have no effect. Address 3 reads zero, and every read returns zero above bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_overrun_i | input | 1 | Receive overrun pulse |
| evt_break_i | input | 1 | Line break pulse |
| evt_parity_i | input | 1 | Parity error pulse |
| evt_framing_i | input | 1 | Framing error pulse |
| evt_rx_tmo_i | input | 1 | Receive time-out pulse |
| rx_fifo_empty_i | input | 1 | Receive FIFO empty level |
| rx_at_trig_i | input | 1 | Receive FIFO at or above its threshold |
| tx_at_trig_i | input | 1 | Transmit FIFO at or below its threshold |
| tx_line_idle_i | input | 1 | Transmitter shift logic idle |
| tx_fifo_empty_i | input | 1 | Transmit FIFO empty |
| cts_i | input | 1 | Clear-to-send pin, asynchronous |
| rx_dma_done_i | input | 1 | Receive DMA completion level |
| tx_dma_done_i | input | 1 | Transmit DMA completion level |
| reg_addr_i | input | 2 | Register select: 0 raw, 1 mask, 2 masked, 3 clear |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data, combinational from `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with REG_W = 16 and SYNC_STAGES = 3. The narrower data word lets it check that writes with every bit set leave only bits 8:0 in the mask and return zeros above them. The extra synchronizer stage makes the clear-to-send latency four edges instead of three, so the bench can check that the latency follows the parameter and is not fixed. Directed tasks cover the case where a set and a clear hit the same bit in one cycle, a software clear while a threshold level stays high, and the DMA levels bypassing a zero mask.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NSRC = 9;
    localparam int NLVL = 3;

    localparam int B_RXL = 0;
    localparam int B_TXL = 1;
    localparam int B_TMO = 2;
    localparam int B_FRM = 3;
    localparam int B_PAR = 4;
    localparam int B_BRK = 5;
    localparam int B_OVR = 6;
    localparam int B_CTS = 7;
    localparam int B_EOT = 8;

    localparam int L_RX  = 0;
    localparam int L_TX  = 1;
    localparam int L_EOT = 2;

    localparam logic [1:0] A_RAW = 2'd0;
    localparam logic [1:0] A_MSK = 2'd1;
    localparam logic [1:0] A_ENA = 2'd2;
    localparam logic [1:0] A_CLR = 2'd3;

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic [NLVL-1:0] lvl_prev;
    } agg_state_t;
endpackage

// File: rtl/irq_cts_detect.sv
module irq_cts_detect #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic chg_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } cts_state_t;

    cts_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin_i};
        st_d.prev = st_q.sync[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign chg_o = st_q.sync[STAGES-1] ^ st_q.prev;
endmodule

// File: rtl/irq_status_cell.sv
module irq_status_cell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic release_i,
    input  logic clr_i,
    output logic bit_o
);
    logic bit_d, bit_q;

    always_comb begin
        bit_d = bit_q & ~clr_i & ~release_i;
        if (set_i) bit_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bit_q <= 1'b0;
        else         bit_q <= bit_d;
    end

    assign bit_o = bit_q;
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
    import uart_irq_pkg::*;
#(
    parameter int REG_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             evt_overrun_i,
    input  logic             evt_break_i,
    input  logic             evt_parity_i,
    input  logic             evt_framing_i,
    input  logic             evt_rx_tmo_i,
    input  logic             rx_fifo_empty_i,
    input  logic             rx_at_trig_i,
    input  logic             tx_at_trig_i,
    input  logic             tx_line_idle_i,
    input  logic             tx_fifo_empty_i,
    input  logic             cts_i,
    input  logic             rx_dma_done_i,
    input  logic             tx_dma_done_i,
    input  logic [1:0]       reg_addr_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic             irq_o
);
    localparam int PAD_W = REG_W - NSRC;

    agg_state_t      state_d, state_q;
    logic [NSRC-1:0] raw_q;
    logic [NSRC-1:0] set_v, rel_v, clr_v;
    logic [NSRC-1:0] masked;
    logic [NLVL-1:0] lvl_now, lvl_rise;
    logic            cts_chg;
    logic            unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata_i[REG_W-1:NSRC];

    irq_cts_detect #(.STAGES(SYNC_STAGES)) u_cts (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (cts_i),
        .chg_o  (cts_chg)
    );

    always_comb begin
        lvl_now        = '0;
        lvl_now[L_RX]  = rx_at_trig_i;
        lvl_now[L_TX]  = tx_at_trig_i;
        lvl_now[L_EOT] = tx_line_idle_i & tx_fifo_empty_i;
        lvl_rise       = lvl_now & ~state_q.lvl_prev;

        set_v        = '0;
        set_v[B_RXL] = lvl_rise[L_RX];
        set_v[B_TXL] = lvl_rise[L_TX];
        set_v[B_TMO] = evt_rx_tmo_i;
        set_v[B_FRM] = evt_framing_i;
        set_v[B_PAR] = evt_parity_i;
        set_v[B_BRK] = evt_break_i;
        set_v[B_OVR] = evt_overrun_i;
        set_v[B_CTS] = cts_chg;
        set_v[B_EOT] = lvl_rise[L_EOT];

        rel_v        = '0;
        rel_v[B_RXL] = ~lvl_now[L_RX];
        rel_v[B_TXL] = ~lvl_now[L_TX];
        rel_v[B_TMO] = rx_fifo_empty_i;
        rel_v[B_EOT] = ~lvl_now[L_EOT];

        clr_v = (reg_wr_i && reg_addr_i == A_CLR) ? reg_wdata_i[NSRC-1:0] : '0;

        state_d          = state_q;
        state_d.lvl_prev = lvl_now;
        if (reg_wr_i && reg_addr_i == A_MSK) state_d.mask = reg_wdata_i[NSRC-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        irq_status_cell u_cell (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .set_i     (set_v[i]),
            .release_i (rel_v[i]),
            .clr_i     (clr_v[i]),
            .bit_o     (raw_q[i])
        );
    end

    assign masked = raw_q & state_q.mask;
    assign irq_o  = (|masked) | rx_dma_done_i | tx_dma_done_i;

    always_comb begin
        unique case (reg_addr_i)
            A_RAW:   reg_rdata_o = {{PAD_W{1'b0}}, raw_q};
            A_MSK:   reg_rdata_o = {{PAD_W{1'b0}}, state_q.mask};
            A_ENA:   reg_rdata_o = {{PAD_W{1'b0}}, masked};
            default: reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/uart_irq_agg_chk.sv
module uart_irq_agg_chk
    import uart_irq_pkg::*;
#(
    parameter int REG_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             evt_overrun_i,
    input logic             evt_framing_i,
    input logic             evt_rx_tmo_i,
    input logic             rx_fifo_empty_i,
    input logic             rx_at_trig_i,
    input logic             rx_dma_done_i,
    input logic             tx_dma_done_i,
    input logic [1:0]       reg_addr_i,
    input logic             reg_wr_i,
    input logic [REG_W-1:0] reg_wdata_i,
    input logic             irq_o,
    input logic [NSRC-1:0]  raw_i,
    input logic [NSRC-1:0]  mask_i
);
    logic clr_frm;
    assign clr_frm = reg_wr_i && (reg_addr_i == A_CLR) && reg_wdata_i[B_FRM];

    AST_RESET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (raw_i == '0 && mask_i == '0)); // R1
    AST_FRM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        raw_i[B_FRM] && !clr_frm |=> raw_i[B_FRM]); // R2
    AST_FRM_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_frm && !evt_framing_i |=> !raw_i[B_FRM]); // R3
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_overrun_i |=> raw_i[B_OVR]); // R4
    AST_RXL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_at_trig_i |=> !raw_i[B_RXL]); // R5
    AST_TMO_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_fifo_empty_i && !evt_rx_tmo_i |=> !raw_i[B_TMO]); // R8
    AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_i == '0) && !rx_dma_done_i && !tx_dma_done_i |-> !irq_o); // R11
    AST_DMA_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_dma_done_i || tx_dma_done_i) |-> irq_o); // R12
endmodule

bind uart_irq_agg uart_irq_agg_chk #(.REG_W(REG_W)) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .evt_overrun_i   (evt_overrun_i),
    .evt_framing_i   (evt_framing_i),
    .evt_rx_tmo_i    (evt_rx_tmo_i),
    .rx_fifo_empty_i (rx_fifo_empty_i),
    .rx_at_trig_i    (rx_at_trig_i),
    .rx_dma_done_i   (rx_dma_done_i),
    .tx_dma_done_i   (tx_dma_done_i),
    .reg_addr_i      (reg_addr_i),
    .reg_wr_i        (reg_wr_i),
    .reg_wdata_i     (reg_wdata_i),
    .irq_o           (irq_o),
    .raw_i           (raw_q),
    .mask_i          (state_q.mask)
);

// File: tb/tb_uart_irq_agg.sv
module tb_uart_irq_agg;
    localparam int REG_W = 16;
    localparam int SYNC  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovr = 0, brk = 0, par = 0, frm = 0, tmo = 0;
    logic rx_empty = 1, rx_trig = 0, tx_trig = 0, tx_idle = 0, tx_empty = 0;
    logic cts = 0, dma_rx = 0, dma_tx = 0;
    logic [1:0] addr = 0;
    logic wr = 0;
    logic [REG_W-1:0] wdata = 0;
    logic [REG_W-1:0] rdata;
    logic irq;
    int checks = 0;
    int errors = 0;
    logic done = 0;

    always #2 clk = ~clk;

    uart_irq_agg #(.REG_W(REG_W), .SYNC_STAGES(SYNC)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .evt_overrun_i(ovr), .evt_break_i(brk), .evt_parity_i(par), .evt_framing_i(frm),
        .evt_rx_tmo_i(tmo), .rx_fifo_empty_i(rx_empty), .rx_at_trig_i(rx_trig),
        .tx_at_trig_i(tx_trig), .tx_line_idle_i(tx_idle), .tx_fifo_empty_i(tx_empty),
        .cts_i(cts), .rx_dma_done_i(dma_rx), .tx_dma_done_i(dma_tx),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [REG_W-1:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wreg(input logic [1:0] a, input logic [REG_W-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1;
        @(negedge clk);
        wr = 0; wdata = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [REG_W-1:0] v;
        rd(0, v); chk("R1 raw", v, 0);
        rd(1, v); chk("R1 mask", v, 0);
        chk("R1 irq", REG_W'(irq), 0);
    endtask

    task automatic t_errors();
        logic [REG_W-1:0] v;
        @(negedge clk); ovr = 1; brk = 1; par = 1; frm = 1;
        @(negedge clk); ovr = 0; brk = 0; par = 0; frm = 0;
        idle(3);
        rd(0, v); chk("R2 sticky errors", v, 16'h0078);
        wreg(3, 16'h0018);
        rd(0, v); chk("R3 partial clear", v, 16'h0060);
        wreg(3, 16'h0060);
        rd(0, v); chk("R3 full clear", v, 0);
    endtask

    task automatic t_set_wins();
        logic [REG_W-1:0] v;
        @(negedge clk); ovr = 1; addr = 3; wdata = 16'h0040; wr = 1;
        @(negedge clk); ovr = 0; wr = 0; wdata = 0;
        rd(0, v); chk("R4 set beats clear", v, 16'h0040);
        wreg(3, 16'h0040);
    endtask

    task automatic t_rx_level();
        logic [REG_W-1:0] v;
        @(negedge clk); rx_trig = 1;
        rd(0, v); chk("R5 rise sets", v, 16'h0001);
        wreg(3, 16'h0001);
        idle(2);
        rd(0, v); chk("R5 clear while high", v, 0);
        @(negedge clk); rx_trig = 0;
        @(negedge clk); rx_trig = 1;
        rd(0, v); chk("R5 rise again", v, 16'h0001);
        @(negedge clk); rx_trig = 0;
        rd(0, v); chk("R5 release", v, 0);
    endtask

    task automatic t_tx_level();
        logic [REG_W-1:0] v;
        @(negedge clk); tx_trig = 1;
        idle(2);
        rd(0, v); chk("R6 tx level set", v, 16'h0002);
        @(negedge clk); tx_trig = 0;
        rd(0, v); chk("R6 tx release", v, 0);
    endtask

    task automatic t_eot();
        logic [REG_W-1:0] v;
        @(negedge clk); tx_idle = 1;
        idle(1);
        rd(0, v); chk("R7 idle alone", v, 0);
        @(negedge clk); tx_empty = 1;
        rd(0, v); chk("R7 both set", v, 16'h0100);
        @(negedge clk); tx_idle = 0;
        rd(0, v); chk("R7 release", v, 0);
        tx_empty = 0;
    endtask

    task automatic t_timeout();
        logic [REG_W-1:0] v;
        @(negedge clk); rx_empty = 0; tmo = 1;
        @(negedge clk); tmo = 0;
        idle(2);
        rd(0, v); chk("R8 timeout set", v, 16'h0004);
        @(negedge clk); rx_empty = 1;
        rd(0, v); chk("R8 empty release", v, 0);
        @(negedge clk); rx_empty = 0; tmo = 1;
        @(negedge clk); tmo = 0;
        wreg(3, 16'h0004);
        rd(0, v); chk("R8 software clear", v, 0);
        rx_empty = 1;
    endtask

    task automatic t_cts();
        logic [REG_W-1:0] v;
        @(negedge clk); cts = 1;
        @(negedge clk); #1 chk("R9 not early", rdata & 16'h0080, 0);
        idle(SYNC + 1);
        rd(0, v); chk("R9 rise detected", v, 16'h0080);
        wreg(3, 16'h0080);
        rd(0, v); chk("R9 cleared", v, 0);
        @(negedge clk); cts = 0;
        idle(SYNC + 2);
        rd(0, v); chk("R9 fall detected", v, 16'h0080);
        wreg(3, 16'h0080);
    endtask

    task automatic t_mask();
        logic [REG_W-1:0] v;
        @(negedge clk); frm = 1;
        @(negedge clk); frm = 0;
        rd(0, v); chk("R10 raw visible unmasked", v, 16'h0008);
        rd(2, v); chk("R10 masked zero", v, 0);
        chk("R11 irq low with zero mask", REG_W'(irq), 0);
        wreg(1, 16'h0008);
        rd(2, v); chk("R10 masked view", v, 16'h0008);
        chk("R11 irq high", REG_W'(irq), 1);
        wreg(3, 16'h0008);
        rd(2, v); chk("R3 masked cleared", v, 0);
        chk("R11 irq drops", REG_W'(irq), 0);
        wreg(1, 0);
    endtask

    task automatic t_dma();
        logic [REG_W-1:0] v;
        @(negedge clk); dma_rx = 1;
        #1 chk("R12 rx dma irq", REG_W'(irq), 1);
        rd(0, v); chk("R12 raw untouched", v, 0);
        @(negedge clk); dma_rx = 0; dma_tx = 1;
        #1 chk("R12 tx dma irq", REG_W'(irq), 1);
        @(negedge clk); dma_tx = 0;
        #1 chk("R12 irq released", REG_W'(irq), 0);
    endtask

    task automatic t_regmap();
        logic [REG_W-1:0] v;
        wreg(0, 16'hFFFF);
        rd(0, v); chk("R13 raw write ignored", v, 0);
        wreg(2, 16'hFFFF);
        rd(1, v); chk("R13 masked write ignored", v, 0);
        wreg(1, 16'hFFFF);
        rd(1, v); chk("R13 mask width", v, 16'h01FF);
        rd(3, v); chk("R13 clear reads zero", v, 0);
        wreg(1, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        t_reset();
        t_errors();
        t_set_wins();
        t_rx_level();
        t_tx_level();
        t_eot();
        t_timeout();
        t_cts();
        t_mask();
        t_dma();
        t_regmap();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule